// File: doc/BRIEF.md
# Dual Condition-Code and Flag Branch Evaluator

This block decides whether a branch is taken, for a processor that runs in two modes: an ordinary program mode and an internal-code mode used for complex operations. Each mode owns its own 2-bit condition code. Because of this, arithmetic and compare operations inside internal code never disturb the condition code that the running program will test later. A dedicated load operation lets internal code hand a result back to the program condition code. The value handed back is either an explicit constant or a copy of its own condition code.

The block also keeps a bank of sixteen local flags that only internal code uses. The flags form four groups of four. They can be loaded as a whole by entry-setup logic, or set and cleared bit by bit. Two kinds of branch query are answered from the current state in the same cycle:

- A mask query tests a 4-bit mask against the condition code of the active mode.
- A flag query tests up to four flags of one group under one of four match rules.

The result is a single `taken` signal. Fetch, target arithmetic and prediction are outside this block.

Top module: `ccflag_branch_eval`

## Requirements
- R1: When `imode`=1, a `cc_we` write stores `cc_wdata` in the internal-code condition code. The program condition code is left unchanged unless `pcc_ld` is asserted in the same cycle.
- R2: When `imode`=0, a `cc_we` write stores `cc_wdata` in the program condition code. The internal-code condition code is left unchanged.
- R3: A mask query (`q_mask_vld`=1) gives `taken` = `q_mask[3-cc]` in the same cycle, where cc is the condition code of the mode named by `imode` in that cycle. So mask bit 3 stands for code 0 and mask bit 0 stands for code 3. A condition-code write in the same cycle is not yet visible to the query.
- R4: `pcc_ld`=1 loads the program condition code on the next edge. With `pcc_src`=0 the value loaded is `pcc_val`. With `pcc_src`=1 it is the internal-code condition code as it stood before that edge. `pcc_ld` takes precedence over a program-mode `cc_we` in the same cycle.
- R5: `setup_we`=1 replaces all sixteen flags with `setup_val` on the next edge, overriding any set or clear request in that cycle. Flag k of group g is bit 4g+k.
- R6: Without `setup_we`, each bit of `flag_set` sets the matching flag and each bit of `flag_clr` clears it. When both name the same flag, the clear wins.
- R7: A flag query (`q_flag_vld`=1) tests the flags of group `q_grp` that are selected by `q_sel`. The rule is chosen by `q_mode`: 0 = all selected flags are 1, 1 = all selected flags are 0, 2 = any selected flag is 1, 3 = any selected flag is 0. The query sees the flag values from before any flag write in the same cycle.
- R8: A flag query with `q_sel`=0 is never taken, whatever the mode.
- R9: When both query kinds are valid, only the mask query decides `taken`. With no query valid, `taken` is 0.
- R10: Reset (`rst_n`=0) clears both condition codes and all sixteen flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imode | input | 1 | 1 = internal-code mode active, 0 = program mode |
| cc_we | input | 1 | Write the active mode's condition code |
| cc_wdata | input | 2 | Condition-code value to write |
| pcc_ld | input | 1 | Load the program condition code |
| pcc_src | input | 1 | 0 = load pcc_val, 1 = copy the internal-code condition code |
| pcc_val | input | 2 | Explicit value for the program condition-code load |
| setup_we | input | 1 | Entry-setup load of the whole flag bank |
| setup_val | input | 16 | Flag values for the setup load |
| flag_set | input | 16 | Per-flag set request |
| flag_clr | input | 16 | Per-flag clear request |
| q_mask_vld | input | 1 | Mask query valid |
| q_mask | input | 4 | Branch mask, bit 3 stands for condition code 0 |
| q_flag_vld | input | 1 | Flag query valid |
| q_grp | input | 2 | Flag group to test |
| q_sel | input | 4 | Flags selected within the group |
| q_mode | input | 2 | Flag match rule |
| taken | output | 1 | Branch taken |

## Verification
The bench builds the block with its default parameters: four groups of four flags and a 2-bit condition code, which gives a 4-bit mask. At that size every condition-code value, every mask position, every group and every one of the sixteen select patterns can be reached. The bench covers them exhaustively in directed steps, then walks a long pseudo-random stream. That stream mixes mode switches, same-cycle writes and queries, overlapping set and clear, and setup loads.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

  typedef enum logic [1:0] {
    FM_ALL_ONE  = 2'd0,
    FM_ALL_ZERO = 2'd1,
    FM_ANY_ONE  = 2'd2,
    FM_ANY_ZERO = 2'd3
  } flag_match_e;

  typedef enum logic {
    PCC_FROM_VAL  = 1'b0,
    PCC_FROM_MILL = 1'b1
  } pcc_src_e;

endpackage

// File: rtl/ccflag_cc_bank.sv
module ccflag_cc_bank #(
  parameter int CC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imode,
  input  logic            cc_we,
  input  logic [CC_W-1:0] cc_wdata,
  input  logic            pcc_ld,
  input  logic            pcc_src,
  input  logic [CC_W-1:0] pcc_val,
  output logic [CC_W-1:0] prog_cc,
  output logic [CC_W-1:0] milli_cc,
  output logic [CC_W-1:0] active_cc
);
  import ccflag_pkg::*;

  logic [CC_W-1:0] prog_nxt;
  logic [CC_W-1:0] milli_nxt;

  always_comb begin
    prog_nxt = prog_cc;
    if (pcc_ld) begin
      if (pcc_src_e'(pcc_src) == PCC_FROM_MILL) prog_nxt = milli_cc;
      else                                       prog_nxt = pcc_val;
    end else if (cc_we && !imode) begin
      prog_nxt = cc_wdata;
    end
  end

  always_comb begin
    milli_nxt = milli_cc;
    if (cc_we && imode) milli_nxt = cc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cc  <= '0;
      milli_cc <= '0;
    end else begin
      prog_cc  <= prog_nxt;
      milli_cc <= milli_nxt;
    end
  end

  assign active_cc = imode ? milli_cc : prog_cc;

endmodule

// File: rtl/ccflag_flag_bank.sv
module ccflag_flag_bank #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 4,
  localparam int NFLAG  = GROUPS * GROUP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_we,
  input  logic [NFLAG-1:0] setup_val,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [NFLAG-1:0] flags
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GROUP_W-1:0] grp_q;
    logic [GROUP_W-1:0] grp_d;
    logic [GROUP_W-1:0] set_g;
    logic [GROUP_W-1:0] clr_g;
    logic [GROUP_W-1:0] ld_g;

    assign set_g = flag_set[g*GROUP_W +: GROUP_W];
    assign clr_g = flag_clr[g*GROUP_W +: GROUP_W];
    assign ld_g  = setup_val[g*GROUP_W +: GROUP_W];

    always_comb begin
      if (setup_we) grp_d = ld_g;
      else          grp_d = (grp_q | set_g) & ~clr_g;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q <= '0;
      else        grp_q <= grp_d;
    end

    assign flags[g*GROUP_W +: GROUP_W] = grp_q;
  end

endmodule

// File: rtl/ccflag_resolve.sv
module ccflag_resolve #(
  parameter int CC_W    = 2,
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 4,
  localparam int MASK_W = 1 << CC_W,
  localparam int NFLAG  = GROUPS * GROUP_W,
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic [CC_W-1:0]    active_cc,
  input  logic [NFLAG-1:0]   flags,
  input  logic               q_mask_vld,
  input  logic [MASK_W-1:0]  q_mask,
  input  logic               q_flag_vld,
  input  logic [GIDX_W-1:0]  q_grp,
  input  logic [GROUP_W-1:0] q_sel,
  input  logic [1:0]         q_mode,
  output logic               mask_hit,
  output logic               flag_hit,
  output logic               taken
);
  import ccflag_pkg::*;

  function automatic logic mask_pick(input logic [MASK_W-1:0] m,
                                     input logic [CC_W-1:0]   cc);
    logic [MASK_W-1:0] rev;
    for (int i = 0; i < MASK_W; i++) rev[i] = m[MASK_W-1-i];
    return rev[cc];
  endfunction

  function automatic logic group_test(input logic [GROUP_W-1:0] bits,
                                      input logic [GROUP_W-1:0] sel,
                                      input flag_match_e        mode);
    logic some_one;
    logic some_zero;
    logic nonempty;
    some_one  = |(bits & sel);
    some_zero = |(~bits & sel);
    nonempty  = |sel;
    case (mode)
      FM_ALL_ONE:  return nonempty && !some_zero;
      FM_ALL_ZERO: return nonempty && !some_one;
      FM_ANY_ONE:  return some_one;
      default:     return some_zero;
    endcase
  endfunction

  logic [GROUP_W-1:0] grp_bits [GROUPS];
  for (genvar g = 0; g < GROUPS; g++) begin : g_split
    assign grp_bits[g] = flags[g*GROUP_W +: GROUP_W];
  end

  logic [GROUP_W-1:0] chosen;
  always_comb begin
    chosen = '0;
    for (int g = 0; g < GROUPS; g++)
      if (q_grp == GIDX_W'(g)) chosen = grp_bits[g];
  end

  assign mask_hit = mask_pick(q_mask, active_cc);
  assign flag_hit = group_test(chosen, q_sel, flag_match_e'(q_mode));

  always_comb begin
    if (q_mask_vld)      taken = mask_hit;
    else if (q_flag_vld) taken = flag_hit;
    else                 taken = 1'b0;
  end

endmodule

// File: rtl/ccflag_branch_eval.sv
module ccflag_branch_eval #(
  parameter int CC_W    = 2,
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 4,
  localparam int MASK_W = 1 << CC_W,
  localparam int NFLAG  = GROUPS * GROUP_W,
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               imode,
  input  logic               cc_we,
  input  logic [CC_W-1:0]    cc_wdata,
  input  logic               pcc_ld,
  input  logic               pcc_src,
  input  logic [CC_W-1:0]    pcc_val,
  input  logic               setup_we,
  input  logic [NFLAG-1:0]   setup_val,
  input  logic [NFLAG-1:0]   flag_set,
  input  logic [NFLAG-1:0]   flag_clr,
  input  logic               q_mask_vld,
  input  logic [MASK_W-1:0]  q_mask,
  input  logic               q_flag_vld,
  input  logic [GIDX_W-1:0]  q_grp,
  input  logic [GROUP_W-1:0] q_sel,
  input  logic [1:0]         q_mode,
  output logic               taken
);

  logic [CC_W-1:0]  prog_cc;
  logic [CC_W-1:0]  milli_cc;
  logic [CC_W-1:0]  active_cc;
  logic [NFLAG-1:0] flags;
  logic             mask_hit;
  logic             flag_hit;

  ccflag_cc_bank #(.CC_W(CC_W)) u_cc (
    .clk       (clk),
    .rst_n     (rst_n),
    .imode     (imode),
    .cc_we     (cc_we),
    .cc_wdata  (cc_wdata),
    .pcc_ld    (pcc_ld),
    .pcc_src   (pcc_src),
    .pcc_val   (pcc_val),
    .prog_cc   (prog_cc),
    .milli_cc  (milli_cc),
    .active_cc (active_cc)
  );

  ccflag_flag_bank #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .setup_we  (setup_we),
    .setup_val (setup_val),
    .flag_set  (flag_set),
    .flag_clr  (flag_clr),
    .flags     (flags)
  );

  ccflag_resolve #(.CC_W(CC_W), .GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_res (
    .active_cc  (active_cc),
    .flags      (flags),
    .q_mask_vld (q_mask_vld),
    .q_mask     (q_mask),
    .q_flag_vld (q_flag_vld),
    .q_grp      (q_grp),
    .q_sel      (q_sel),
    .q_mode     (q_mode),
    .mask_hit   (mask_hit),
    .flag_hit   (flag_hit),
    .taken      (taken)
  );

endmodule

// File: rtl/ccflag_branch_eval_chk.sv
module ccflag_branch_eval_chk #(
  parameter int CC_W    = 2,
  parameter int GROUP_W = 4,
  parameter int NFLAG   = 16,
  parameter int MASK_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               imode,
  input logic               pcc_ld,
  input logic               pcc_src,
  input logic               setup_we,
  input logic [NFLAG-1:0]   setup_val,
  input logic [NFLAG-1:0]   flag_clr,
  input logic               q_mask_vld,
  input logic [MASK_W-1:0]  q_mask,
  input logic               q_flag_vld,
  input logic [GROUP_W-1:0] q_sel,
  input logic               taken,
  input logic [CC_W-1:0]    prog_cc,
  input logic [CC_W-1:0]    milli_cc,
  input logic [NFLAG-1:0]   flags
);

  AST_PCC_HELD_IN_MILLI: assert property (@(posedge clk) disable iff (!rst_n)
    (imode && !pcc_ld) |=> $stable(prog_cc)); // R1

  AST_MCC_HELD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !imode |=> $stable(milli_cc)); // R2

  AST_FULL_MASK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (q_mask_vld && (&q_mask)) |-> taken); // R3

  AST_PCC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (pcc_ld && pcc_src) |=> (prog_cc == $past(milli_cc))); // R4

  AST_SETUP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    setup_we |=> (flags == $past(setup_val))); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_we && (flag_clr != '0)) |=> ((flags & $past(flag_clr)) == '0)); // R6

  AST_EMPTY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flag_vld && !q_mask_vld && (q_sel == '0)) |-> !taken); // R8

  AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_mask_vld && !q_flag_vld) |-> !taken); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == '0 && prog_cc == '0 && milli_cc == '0)); // R10

endmodule

bind ccflag_branch_eval ccflag_branch_eval_chk #(
  .CC_W(CC_W), .GROUP_W(GROUP_W), .NFLAG(NFLAG), .MASK_W(MASK_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imode      (imode),
  .pcc_ld     (pcc_ld),
  .pcc_src    (pcc_src),
  .setup_we   (setup_we),
  .setup_val  (setup_val),
  .flag_clr   (flag_clr),
  .q_mask_vld (q_mask_vld),
  .q_mask     (q_mask),
  .q_flag_vld (q_flag_vld),
  .q_sel      (q_sel),
  .taken      (taken),
  .prog_cc    (prog_cc),
  .milli_cc   (milli_cc),
  .flags      (flags)
);

// File: tb/sim_ccflag_branch_eval.sv
`timescale 1ns/1ps
module sim_ccflag_branch_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imode = 1'b0;
  logic        cc_we = 1'b0;
  logic [1:0]  cc_wdata = '0;
  logic        pcc_ld = 1'b0;
  logic        pcc_src = 1'b0;
  logic [1:0]  pcc_val = '0;
  logic        setup_we = 1'b0;
  logic [15:0] setup_val = '0;
  logic [15:0] flag_set = '0;
  logic [15:0] flag_clr = '0;
  logic        q_mask_vld = 1'b0;
  logic [3:0]  q_mask = '0;
  logic        q_flag_vld = 1'b0;
  logic [1:0]  q_grp = '0;
  logic [3:0]  q_sel = '0;
  logic [1:0]  q_mode = '0;
  logic        taken;

  always #4 clk = ~clk;

  ccflag_branch_eval u0 (
    .clk(clk), .rst_n(rst_n), .imode(imode), .cc_we(cc_we), .cc_wdata(cc_wdata),
    .pcc_ld(pcc_ld), .pcc_src(pcc_src), .pcc_val(pcc_val),
    .setup_we(setup_we), .setup_val(setup_val), .flag_set(flag_set), .flag_clr(flag_clr),
    .q_mask_vld(q_mask_vld), .q_mask(q_mask), .q_flag_vld(q_flag_vld),
    .q_grp(q_grp), .q_sel(q_sel), .q_mode(q_mode), .taken(taken)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int        m_pcc;
  int        m_mcc;
  bit [15:0] m_flags;

  function automatic bit ref_mask(int cc, bit [3:0] m);
    return m[3 - cc];
  endfunction

  function automatic bit ref_flag(bit [15:0] f, int grp, bit [3:0] sel, int mode);
    int nsel = 0;
    int nones = 0;
    for (int k = 0; k < 4; k++) begin
      if (sel[k]) begin
        nsel++;
        if (f[grp*4 + k]) nones++;
      end
    end
    if (nsel == 0) return 0;
    case (mode)
      0: return nones == nsel;
      1: return nones == 0;
      2: return nones > 0;
      default: return nones < nsel;
    endcase
  endfunction

  function automatic bit expect_taken();
    int cc = imode ? m_mcc : m_pcc;
    if (q_mask_vld) return ref_mask(cc, q_mask);
    if (q_flag_vld) return ref_flag(m_flags, q_grp, q_sel, q_mode);
    return 0;
  endfunction

  task automatic clear_inputs();
    cc_we = 0; pcc_ld = 0; setup_we = 0; flag_set = '0; flag_clr = '0;
    q_mask_vld = 0; q_flag_vld = 0;
  endtask

  // Compare the current cycle's output, then advance one clock and the model.
  task automatic step(string tag);
    bit exp;
    int old_mcc;
    #1;
    exp = expect_taken();
    checks++;
    if (taken !== exp) begin
      fails++;
      $display("FAIL %s taken actual %0b expected %0b at %0t", tag, taken, exp, $time);
    end
    @(posedge clk);
    old_mcc = m_mcc;
    if (pcc_ld) m_pcc = pcc_src ? old_mcc : int'(pcc_val);
    else if (cc_we && !imode) m_pcc = cc_wdata;
    if (cc_we && imode) m_mcc = cc_wdata;
    if (setup_we) m_flags = setup_val;
    else m_flags = (m_flags | flag_set) & ~flag_clr;
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic mask_q(bit md, bit [3:0] m, string tag);
    imode = md; q_mask_vld = 1; q_mask = m;
    step(tag);
  endtask

  task automatic flag_q(int g, bit [3:0] s, int md, string tag);
    q_flag_vld = 1; q_grp = 2'(g); q_sel = s; q_mode = 2'(md);
    step(tag);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_pcc = 0; m_mcc = 0; m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    mask_q(0, 4'b1000, "R10");
    mask_q(1, 4'b1000, "R10");
    for (int g = 0; g < 4; g++) flag_q(g, 4'hF, 1, "R10");

    // R1: internal-code mode writes only its own code
    imode = 1; cc_we = 1; cc_wdata = 2'd2; step("R1");
    for (int c = 0; c < 4; c++) mask_q(1, 4'(1 << (3 - c)), "R1");
    for (int c = 0; c < 4; c++) mask_q(0, 4'(1 << (3 - c)), "R1");

    // R2: program mode writes only the program code
    imode = 0; cc_we = 1; cc_wdata = 2'd3; step("R2");
    mask_q(0, 4'b0001, "R2");
    mask_q(1, 4'b0010, "R2");
    mask_q(1, 4'b1101, "R2");

    // R3: same-cycle write is not visible, all masks
    imode = 0; cc_we = 1; cc_wdata = 2'd1; q_mask_vld = 1; q_mask = 4'b0001; step("R3");
    for (int m = 0; m < 16; m++) mask_q(0, 4'(m), "R3");
    for (int m = 0; m < 16; m++) mask_q(1, 4'(m), "R3");

    // R4: explicit load, copy, and precedence over program write
    pcc_ld = 1; pcc_src = 0; pcc_val = 2'd0; step("R4");
    mask_q(0, 4'b1000, "R4");
    imode = 0; pcc_ld = 1; pcc_src = 1; cc_we = 1; cc_wdata = 2'd3; step("R4");
    mask_q(0, 4'b0010, "R4");
    imode = 1; pcc_ld = 1; pcc_src = 1; cc_we = 1; cc_wdata = 2'd0; step("R4");
    mask_q(0, 4'b0010, "R4");
    mask_q(1, 4'b1000, "R4");

    // R5: setup load overrides set and clear
    setup_we = 1; setup_val = 16'hA5C3; flag_set = 16'hFFFF; flag_clr = 16'hFFFF; step("R5");
    for (int g = 0; g < 4; g++)
      for (int k = 0; k < 4; k++) flag_q(g, 4'(1 << k), 0, "R5");

    // R6: set and clear, clear wins on overlap
    flag_set = 16'h0F0F; flag_clr = 16'h0101; step("R6");
    for (int g = 0; g < 4; g++) flag_q(g, 4'hF, 2, "R6");
    for (int g = 0; g < 4; g++) flag_q(g, 4'hF, 0, "R6");
    for (int g = 0; g < 4; g++) flag_q(g, 4'b0001, 1, "R6");

    // R7: all groups, selects, modes; same-cycle write not visible
    for (int g = 0; g < 4; g++)
      for (int s = 1; s < 16; s++)
        for (int md = 0; md < 4; md++) flag_q(g, 4'(s), md, "R7");
    flag_clr = 16'hFFFF; q_flag_vld = 1; q_grp = 0; q_sel = 4'b0010; q_mode = 2; step("R7");
    flag_q(0, 4'b0010, 2, "R7");

    // R8: empty select in every mode and group
    setup_we = 1; setup_val = 16'h3C96; step("R5");
    for (int g = 0; g < 4; g++)
      for (int md = 0; md < 4; md++) flag_q(g, 4'b0000, md, "R8");

    // R9: priority and idle
    imode = 0; q_mask_vld = 1; q_mask = 4'b0000; q_flag_vld = 1; q_grp = 1;
    q_sel = 4'hF; q_mode = 2; step("R9");
    imode = 0; q_mask_vld = 1; q_mask = 4'b1111; q_flag_vld = 1; q_grp = 0;
    q_sel = 4'b0000; q_mode = 3; step("R9");
    step("R9");

    // Random stream covering all requirements together
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      imode     = r[0];
      cc_we     = r[1];
      cc_wdata  = r[3:2];
      pcc_ld    = (r[7:4] == 0);
      pcc_src   = r[8];
      pcc_val   = r[10:9];
      setup_we  = (r[15:11] == 0);
      setup_val = 16'($urandom);
      flag_set  = 16'($urandom) & 16'($urandom);
      flag_clr  = 16'($urandom) & 16'($urandom);
      q_mask_vld = r[16] & r[17];
      q_mask     = r[21:18];
      q_flag_vld = r[22] | r[23];
      q_grp      = r[25:24];
      q_sel      = r[29:26];
      q_mode     = r[31:30];
      if (q_mask_vld) step("R3");
      else if (q_flag_vld && q_sel == 0) step("R8");
      else if (q_flag_vld) step("R7");
      else step("R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule